// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Command Controller

This block is the digital control core of a small serial EEPROM with a three-wire interface plus chip select. A host raises chip select, clocks in a start bit, a two-bit opcode and a six-bit word address, and for data-carrying commands a sixteen-bit data word. Everything is sent most significant bit first. The block decodes the frame and acts on it. A read streams a stored word back on the data output. The enable and disable commands set or clear a write-enable latch. Every command that modifies storage (single write, single erase, erase-all, write-all) is first only armed. The programming step itself is self-timed. It starts when chip select falls after a complete frame and runs on the system clock with no serial clock edges. Storage is an on-chip register array of 64 words of 16 bits.

The serial clock, chip select and data input are sampled on the system clock. A serial bit is taken on a detected rising edge of the serial clock. While a programming cycle runs, or after it has ended, the host can raise chip select and poll the data output to read the ready/busy status.

The controller is a state machine with eight states. IDLE waits for a start bit. CMD shifts in the opcode and the address. DATA shifts in a data word. READ shifts a stored word out. ARMED holds a complete, permitted modify command until chip select falls. DONE ignores any further clocks until chip select falls. BUSY runs the self-timed cycle. READY reports completion.

The transitions are as follows:
- IDLE goes to CMD on a start bit, and READY does the same.
- CMD goes to READ for a read.
- CMD goes to DATA for a write or a write-all.
- CMD goes to ARMED for an erase or an erase-all when the latch is set, and to DONE otherwise. It also goes to DONE for the enable and disable commands.
- DATA goes to ARMED when the latch is set, and to DONE otherwise.
- CMD, DATA, READ and DONE go back to IDLE when chip select is low.
- ARMED goes to BUSY when chip select goes low.
- BUSY goes to READY when the cycle counter expires.
- READY goes to IDLE when chip select falls.

Top module: `mw_eeprom`

## Requirements
- R1: After reset the state is IDLE, the data output is not driven, and the write-enable latch is cleared. A modify command sent before an enable command changes nothing.
- R2: Opcode 00 with the two top address bits 11 sets the write-enable latch. Opcode 00 with the two top address bits 00 clears it. The latch keeps its value until the next such command or a reset.
- R3: While the latch is cleared, write, erase, erase-all and write-all frames arm nothing. No busy status follows, and the storage is unchanged.
- R4: Opcode 10 is a read. After the last address bit, the data output carries the addressed word MSB first. It advances one bit per serial clock rising edge. Reads work whatever the latch state.
- R5: Opcode 01 is a write. It is followed by 16 data bits MSB first, and it stores the data at the address.
- R6: Opcode 11 is an erase. It sets the addressed word to 16'hFFFF.
- R7: Opcode 00 with the top address bits 10 is an erase-all. It sets every word to 16'hFFFF.
- R8: Opcode 00 with the top address bits 01 is a write-all. It is followed by 16 data bits, and it writes that word to every location.
- R9: An armed command starts a cycle of BUSY_CYCLES system clocks on the falling edge of chip select. No serial clock is needed during the cycle. The storage is updated when the cycle ends.
- R10: With chip select high during the cycle, the output is driven low (busy). Once the cycle has ended, the output is driven high (ready).
- R11: The output enable is low whenever chip select is low.
- R12: Serial frames sent while the cycle runs are ignored, including the enable and disable commands.
- R13: If chip select falls before a frame is complete, the partial frame is discarded and no cycle starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; also times the self-timed cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| cs | input | 1 | Chip select, active high |
| sclk | input | 1 | Serial clock; bits are taken on its rising edge |
| din | input | 1 | Serial data input |
| dout | output | 1 | Serial data output (read data or ready/busy status) |
| dout_en | output | 1 | Output enable; low means high-impedance |

## Verification
Most internal faults show up at the ports within one frame. A wrong latch value makes a guarded write either take effect or vanish, and the next read of that word shows it. A mis-decoded opcode lands data at the wrong location, or in every location, which the readback of a neighbouring word reveals. A wrong state in the BUSY/READY pair appears on the status poll that directly follows a chip select rise. A counter of the wrong length moves the busy-to-ready change outside the sampled window. A partial frame that is wrongly kept shows as a busy status where none is expected.

// File: rtl/mw_pkg.sv
package mw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_DATA,
        ST_READ,
        ST_ARMED,
        ST_DONE,
        ST_BUSY,
        ST_READY
    } mw_state_e;

    typedef enum logic [1:0] {
        PK_WRITE,
        PK_ERASE,
        PK_WRALL,
        PK_ERALL
    } mw_pend_e;

    localparam logic [1:0] OP_EXT   = 2'b00;
    localparam logic [1:0] OP_WRITE = 2'b01;
    localparam logic [1:0] OP_READ  = 2'b10;
    localparam logic [1:0] OP_ERASE = 2'b11;

    localparam logic [1:0] EXT_LOCK  = 2'b00;
    localparam logic [1:0] EXT_WRALL = 2'b01;
    localparam logic [1:0] EXT_ERALL = 2'b10;
    localparam logic [1:0] EXT_OPEN  = 2'b11;

endpackage

// File: rtl/mw_edge.sv
module mw_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic cs,
    input  logic sclk,
    output logic sclk_rise,
    output logic cs_fall
);
    logic sclk_q;
    logic cs_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q <= 1'b0;
            cs_q   <= 1'b0;
        end else begin
            sclk_q <= sclk;
            cs_q   <= cs;
        end
    end

    assign sclk_rise = sclk & ~sclk_q;
    assign cs_fall   = ~cs & cs_q;
endmodule

// File: rtl/mw_timer.sv
module mw_timer #(
    parameter int CYCLES = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done
);
    localparam int TW = $clog2(CYCLES + 1);

    logic [TW-1:0] remain;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (start) begin
            remain <= TW'(CYCLES);
        end else if (remain != '0) begin
            remain <= remain - 1'b1;
        end
    end

    assign busy = (remain != '0);
    assign done = (remain == TW'(1));
endmodule

// File: rtl/mw_array.sv
module mw_array #(
    parameter int AW = 6,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          wr_one,
    input  logic          wr_all,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (wr_all || (wr_one && (waddr == AW'(i)))) begin
                mem[i] <= wdata;
            end
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/mw_eeprom.sv
module mw_eeprom
    import mw_pkg::*;
#(
    parameter int AW          = 6,
    parameter int DW          = 16,
    parameter int BUSY_CYCLES = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs,
    input  logic sclk,
    input  logic din,
    output logic dout,
    output logic dout_en
);
    localparam int FRAME_W = 2 + AW;
    localparam int MAXW    = (FRAME_W > DW) ? FRAME_W : DW;
    localparam int CNT_W   = $clog2(MAXW + 1);

    mw_state_e state, state_nx;

    logic [CNT_W-1:0]   cnt;
    logic [FRAME_W-1:0] sh;
    logic [DW-1:0]      data_sh;
    logic [DW-1:0]      rd_sh;
    logic               wen;
    mw_pend_e           pend_kind;
    logic [AW-1:0]      pend_addr;
    logic [DW-1:0]      pend_data;

    logic sclk_rise, cs_fall;
    logic tmr_start, tmr_busy, tmr_done;
    logic wr_one, wr_all, commit;
    logic [DW-1:0] rdata;
    logic drive, dval;

    // frame decode views
    logic [FRAME_W-1:0] frame_full;
    logic [DW-1:0]      data_full;
    logic [1:0]         f_op;
    logic [1:0]         f_ext;
    logic [AW-1:0]      f_addr;
    logic               cmd_last, data_last, bit_in;

    mw_edge u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs        (cs),
        .sclk      (sclk),
        .sclk_rise (sclk_rise),
        .cs_fall   (cs_fall)
    );

    mw_timer #(.CYCLES(BUSY_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (tmr_start),
        .busy  (tmr_busy),
        .done  (tmr_done)
    );

    mw_array #(.AW(AW), .DW(DW)) u_array (
        .clk    (clk),
        .wr_one (wr_one),
        .wr_all (wr_all),
        .waddr  (pend_addr),
        .wdata  (pend_data),
        .raddr  (f_addr),
        .rdata  (rdata)
    );

    assign bit_in     = cs & sclk_rise;
    assign frame_full = {sh[FRAME_W-2:0], din};
    assign data_full  = {data_sh[DW-2:0], din};
    assign f_op       = frame_full[FRAME_W-1 -: 2];
    assign f_addr     = frame_full[AW-1:0];
    assign f_ext      = frame_full[AW-1 -: 2];
    assign cmd_last   = (state == ST_CMD)  && bit_in && (cnt == CNT_W'(FRAME_W - 1));
    assign data_last  = (state == ST_DATA) && bit_in && (cnt == CNT_W'(DW - 1));

    assign tmr_start = (state == ST_ARMED) && !cs;
    assign commit    = (state == ST_BUSY) && tmr_done;
    assign wr_one    = commit && ((pend_kind == PK_WRITE) || (pend_kind == PK_ERASE));
    assign wr_all    = commit && ((pend_kind == PK_WRALL) || (pend_kind == PK_ERALL));

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (bit_in && din) state_nx = ST_CMD;
            end
            ST_CMD: begin
                if (!cs) begin
                    state_nx = ST_IDLE;
                end else if (cmd_last) begin
                    unique case (f_op)
                        OP_READ:  state_nx = ST_READ;
                        OP_WRITE: state_nx = ST_DATA;
                        OP_ERASE: state_nx = wen ? ST_ARMED : ST_DONE;
                        OP_EXT: begin
                            unique case (f_ext)
                                EXT_WRALL: state_nx = ST_DATA;
                                EXT_ERALL: state_nx = wen ? ST_ARMED : ST_DONE;
                                EXT_OPEN,
                                EXT_LOCK:  state_nx = ST_DONE;
                            endcase
                        end
                    endcase
                end
            end
            ST_DATA: begin
                if (!cs) begin
                    state_nx = ST_IDLE;
                end else if (data_last) begin
                    state_nx = wen ? ST_ARMED : ST_DONE;
                end
            end
            ST_READ, ST_DONE: begin
                if (!cs) state_nx = ST_IDLE;
            end
            ST_ARMED: begin
                if (!cs) state_nx = ST_BUSY;
            end
            ST_BUSY: begin
                if (tmr_done) state_nx = ST_READY;
            end
            ST_READY: begin
                if (cs_fall) begin
                    state_nx = ST_IDLE;
                end else if (bit_in && din) begin
                    state_nx = ST_CMD;
                end
            end
        endcase
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt       <= '0;
            sh        <= '0;
            data_sh   <= '0;
            rd_sh     <= '0;
            wen       <= 1'b0;
            pend_kind <= PK_WRITE;
            pend_addr <= '0;
            pend_data <= '0;
        end else begin
            case (state)
                ST_IDLE, ST_READY: begin
                    if (bit_in && din) begin
                        cnt <= '0;
                        sh  <= '0;
                    end
                end
                ST_CMD: begin
                    if (bit_in) begin
                        sh  <= frame_full;
                        cnt <= cnt + 1'b1;
                        if (cmd_last) begin
                            cnt       <= '0;
                            pend_addr <= f_addr;
                            rd_sh     <= rdata;
                            unique case (f_op)
                                OP_READ:  ;
                                OP_WRITE: pend_kind <= PK_WRITE;
                                OP_ERASE: begin
                                    pend_kind <= PK_ERASE;
                                    pend_data <= '1;
                                end
                                OP_EXT: begin
                                    unique case (f_ext)
                                        EXT_OPEN:  wen <= 1'b1;
                                        EXT_LOCK:  wen <= 1'b0;
                                        EXT_ERALL: begin
                                            pend_kind <= PK_ERALL;
                                            pend_data <= '1;
                                        end
                                        EXT_WRALL: pend_kind <= PK_WRALL;
                                    endcase
                                end
                            endcase
                        end
                    end
                end
                ST_DATA: begin
                    if (bit_in) begin
                        data_sh <= data_full;
                        cnt     <= cnt + 1'b1;
                        if (data_last) pend_data <= data_full;
                    end
                end
                ST_READ: begin
                    if (bit_in) rd_sh <= {rd_sh[DW-2:0], 1'b0};
                end
                default: ;
            endcase
        end
    end

    // output logic
    always_comb begin
        drive = 1'b0;
        dval  = 1'b0;
        unique case (state)
            ST_READ: begin
                drive = 1'b1;
                dval  = rd_sh[DW-1];
            end
            ST_BUSY: begin
                drive = 1'b1;
                dval  = 1'b0;
            end
            ST_READY: begin
                drive = 1'b1;
                dval  = 1'b1;
            end
            ST_IDLE, ST_CMD, ST_DATA, ST_ARMED, ST_DONE: begin
                drive = 1'b0;
                dval  = 1'b0;
            end
        endcase
    end

    assign dout_en = cs & drive;
    assign dout    = dout_en & dval;
endmodule

// File: rtl/mw_eeprom_chk.sv
module mw_eeprom_chk (
    input logic clk,
    input logic rst_n,
    input logic cs,
    input logic dout,
    input logic dout_en,
    input logic sclk_rise,
    input logic cs_fall,
    input logic wen,
    input logic tmr_busy,
    input logic arr_we
);
    // R1
    reset_latch_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !wen);

    // R2
    latch_on_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(wen) |-> $past(sclk_rise));

    // R3
    guarded_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> wen);

    // R9
    cycle_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tmr_busy) |-> $past(cs_fall));

    // R10
    busy_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_busy && cs) |-> (dout_en && !dout));

    // R11
    hiz_when_deselected_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cs |-> !dout_en);

    // R12
    busy_latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_busy && sclk_rise) |=> $stable(wen));
endmodule

bind mw_eeprom mw_eeprom_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs        (cs),
    .dout      (dout),
    .dout_en   (dout_en),
    .sclk_rise (sclk_rise),
    .cs_fall   (cs_fall),
    .wen       (wen),
    .tmr_busy  (tmr_busy),
    .arr_we    (wr_one | wr_all)
);

// File: tb/sim_mw_eeprom.sv
module sim_mw_eeprom;
    localparam int CYC = 64;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs = 1'b0;
    logic sclk = 1'b0;
    logic din = 1'b0;
    logic dout, dout_en;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    logic [15:0] exp_q[$];
    logic [15:0] got_q[$];
    string       tag_q[$];

    always #4 clk = ~clk;

    mw_eeprom #(.AW(6), .DW(16), .BUSY_CYCLES(CYC)) u0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs      (cs),
        .sclk    (sclk),
        .din     (din),
        .dout    (dout),
        .dout_en (dout_en)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    // monitor: pops and compares read results
    initial begin
        forever begin
            @(negedge clk);
            if (got_q.size() > 0 && exp_q.size() > 0) begin
                logic [15:0] g, e;
                string t;
                g = got_q.pop_front();
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(g == e, t, g, e);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    task automatic send_bit(input logic b);
        @(negedge clk);
        din  = b;
        sclk = 1'b0;
        repeat (2) @(negedge clk);
        sclk = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic cs_up();
        @(negedge clk);
        cs = 1'b1; sclk = 1'b0; din = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic cs_down();
        @(negedge clk);
        cs = 1'b0; sclk = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic frame_bits(input logic [1:0] op, input logic [5:0] a);
        send_bit(1'b1);
        for (int i = 1; i >= 0; i--) send_bit(op[i]);
        for (int i = 5; i >= 0; i--) send_bit(a[i]);
    endtask

    task automatic send_frame(input logic [1:0] op, input logic [5:0] a);
        cs_up();
        frame_bits(op, a);
    endtask

    task automatic send_word(input logic [15:0] d);
        for (int i = 15; i >= 0; i--) send_bit(d[i]);
    endtask

    // R9 R10 R11: falling cs starts cycle, status polled, then deselect
    task automatic run_cycle(input string tag);
        cs_down();
        cs_up();
        check(dout_en && !dout, {"R10 busy early ", tag}, {dout_en, dout}, 2'b10);
        repeat (CYC - 10) @(negedge clk);
        check(dout_en && !dout, {"R9 busy late ", tag}, {dout_en, dout}, 2'b10);
        repeat (10) @(negedge clk);
        check(dout_en && dout, {"R10 ready ", tag}, {dout_en, dout}, 2'b11);
        cs_down();
        check(!dout_en, {"R11 hiz ", tag}, dout_en, 0);
    endtask

    // R3 R13: no cycle must follow
    task automatic expect_idle(input string tag);
        cs_down();
        cs_up();
        check(!dout_en, tag, dout_en, 0);
        cs_down();
    endtask

    task automatic write_word(input logic [5:0] a, input logic [15:0] d, input string tag);
        send_frame(2'b01, a);
        send_word(d);
        run_cycle(tag);
    endtask

    task automatic read_check(input logic [5:0] a, input logic [15:0] e, input string tag);
        logic [15:0] w;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        send_frame(2'b10, a);
        for (int i = 15; i >= 0; i--) begin
            w[i] = dout;
            if (i > 0) send_bit(1'b0);
        end
        got_q.push_back(w);
        cs_down();
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; cs = 1'b0; sclk = 1'b0; din = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        do_reset();
        // R1: output not driven after reset, with cs low and high
        check(!dout_en, "R1 reset hiz", dout_en, 0);
        cs_up();
        check(!dout_en, "R1 idle cs high", dout_en, 0);
        cs_down();

        // R2 enable, then R5 write and R4 read
        send_frame(2'b00, 6'b110000); cs_down();
        write_word(6'd5, 16'hA5A5, "R5 w5");
        read_check(6'd5, 16'hA5A5, "R4 R5 read a5");
        write_word(6'd9, 16'h3C0F, "R5 w9");
        read_check(6'd9, 16'h3C0F, "R5 read a9");

        // R6 erase
        send_frame(2'b11, 6'd9);
        run_cycle("R6 erase");
        read_check(6'd9, 16'hFFFF, "R6 erased a9");
        read_check(6'd5, 16'hA5A5, "R6 neighbour a5");

        // R2 disable, R3 guarded write and erase ignored, R4 read still works
        send_frame(2'b00, 6'b001111); cs_down();
        send_frame(2'b01, 6'd5); send_word(16'h1234);
        expect_idle("R3 no cycle after locked write");
        send_frame(2'b11, 6'd5);
        expect_idle("R3 no cycle after locked erase");
        read_check(6'd5, 16'hA5A5, "R3 R4 a5 kept");

        // R1: reset clears the latch
        send_frame(2'b00, 6'b110000); cs_down();
        do_reset();
        send_frame(2'b11, 6'd5);
        expect_idle("R1 no cycle after reset");
        read_check(6'd5, 16'hA5A5, "R1 a5 kept");

        // R13 partial frame
        send_frame(2'b00, 6'b111111); cs_down();
        cs_up();
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
        send_bit(1'b0); send_bit(1'b0); send_bit(1'b0);
        expect_idle("R13 partial discarded");
        read_check(6'd5, 16'hA5A5, "R13 a5 kept");

        // R12 disable command during busy ignored
        send_frame(2'b01, 6'd20); send_word(16'h0F0F);
        cs_down();
        cs_up();
        frame_bits(2'b00, 6'b000000);
        repeat (CYC + 10) @(negedge clk);
        cs_down();
        write_word(6'd21, 16'h1111, "R12 latch kept");
        read_check(6'd21, 16'h1111, "R12 a21");
        read_check(6'd20, 16'h0F0F, "R12 a20");

        // R8 write all
        send_frame(2'b00, 6'b010000); send_word(16'h5A5A);
        run_cycle("R8 wrall");
        read_check(6'd0, 16'h5A5A, "R8 a0");
        read_check(6'd63, 16'h5A5A, "R8 a63");
        read_check(6'd9, 16'h5A5A, "R8 a9");

        // R7 erase all
        send_frame(2'b00, 6'b100000);
        run_cycle("R7 erall");
        read_check(6'd0, 16'hFFFF, "R7 a0");
        read_check(6'd33, 16'hFFFF, "R7 a33");

        repeat (4) @(negedge clk);
        summary();
    end
endmodule